// File: doc/BRIEF.md
# Asynchronous DRAM Access Sequencer

This block sits between a synchronous host and an asynchronous DRAM device. The host sends a read or write in one cycle over a valid/ready handshake. The request carries a row address, a column address, a write flag and write data. The sequencer then plays the access out on the memory pins in two phases. First the row goes onto the shared address bus and the active-low row strobe falls. Later the column replaces it, and the active-low column strobe falls.

All timing is set in nanoseconds through parameters and rounded up to whole clock cycles. The row-to-column delay is the row access time minus the column access time. The column strobe stays low for the column access time, so the row strobe stays low for the full row access time. On a read, the data bus is sampled at the end of the last column-strobe cycle and handed to the host with a one-cycle valid pulse. Both strobes then rise together, and a precharge interval follows before the next access may begin. While an external refresh grant is high, no access is accepted and the bus stays idle.

Top module: `dseq_top`

## Requirements
- R1: During and directly after reset, memRasN, memCasN and memWeN are 1, memDoutEn and rdValid are 0, and reqReady is 1.
- R2: A request is accepted on a clock edge where reqValid and reqReady are both 1. reqReady is then 0 from the next cycle until the precharge ends, and returns to 1 in the first cycle after it.
- R3: memRasN falls in the first cycle after acceptance. The row address is on memAddr from that cycle for RCD−1 cycles, where RCD = ceil(RAC_NS/CLK_NS) − ceil(CAC_NS/CLK_NS), with a minimum of 2 (9 at defaults).
- R4: The column address replaces the row address in the last cycle before memCasN falls. memCasN falls RCD cycles after memRasN, and memAddr does not change while memCasN is low.
- R5: memCasN stays low for ceil(CAC_NS/CLK_NS) cycles (3). memRasN stays low for RCD plus that count (12). Both rise in the same cycle, and memCasN is never low while memRasN is high.
- R6: On a read, memDin is sampled at the clock edge that ends the last memCasN-low cycle. In the next cycle rdData holds that value and rdValid is 1 for exactly one cycle. A write never raises rdValid.
- R7: On a write, memWeN is 0 and memDoutEn is 1, with memDout equal to the request's write data. This holds from the column-address cycle through the last memCasN-low cycle, so memWeN is already low when memCasN falls. On a read, memWeN stays 1 and memDoutEn stays 0.
- R8: After the strobes rise, memRasN stays 1 for at least ceil(PRE_NS/CLK_NS) cycles (8) before it can fall again.
- R9: While refreshGrant is 1, reqReady is 0, no request is accepted even if reqValid is 1, and memRasN does not fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Sequencer can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqRow | input | ROW_W | Row part of the address |
| reqCol | input | COL_W | Column part of the address |
| reqWdata | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data returned to the host |
| rdValid | output | 1 | One-cycle pulse when rdData is new |
| refreshGrant | input | 1 | Refresh in progress; blocks new accesses |
| memAddr | output | max(ROW_W,COL_W) | Multiplexed row/column address bus |
| memRasN | output | 1 | Active-low row strobe |
| memCasN | output | 1 | Active-low column strobe |
| memWeN | output | 1 | Active-low write enable |
| memDout | output | DATA_W | Data driven to memory on writes |
| memDoutEn | output | 1 | Output enable for memDout |
| memDin | input | DATA_W | Data returned by memory |

## Verification
A refresh grant and a host request can arrive in the same cycle. The bench provokes this by raising refreshGrant and reqValid together for several cycles before an access. In each of those cycles it checks that reqReady stays 0 and memRasN stays high. It then checks that the held request is accepted on the first edge after the grant drops, and that the access that follows has the normal strobe timing. Random reads and writes over a small address range, including writes followed by reads of the same address, are compared cycle by cycle with a pin schedule that the bench computes from the nanosecond parameters.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

  typedef enum logic [1:0] {
    S_IDLE,
    S_ROW,
    S_COL,
    S_PRE
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;  // capture host request
    logic rasOn;    // row strobe active
    logic casOn;    // column strobe active
    logic selCol;   // column address on bus
    logic weWin;    // write window (write enable / data drive)
    logic capRd;    // sample memory data at this edge
  } strobe_t;

  function automatic int cyclesOf(input int ns, input int clkNs);
    return (ns + clkNs - 1) / clkNs;
  endfunction

  function automatic int atLeast(input int v, input int lo);
    return (v < lo) ? lo : v;
  endfunction

endpackage

// File: rtl/dseq_ctrl.sv
module dseq_ctrl
  import dseq_pkg::*;
#(
  parameter int RCD_CYC = 9,
  parameter int CAC_CYC = 3,
  parameter int PRE_CYC = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    refreshGrant,
  output logic    reqReady,
  output strobe_t strb
);

  localparam int MAXC  = (RCD_CYC > CAC_CYC) ? ((RCD_CYC > PRE_CYC) ? RCD_CYC : PRE_CYC)
                                             : ((CAC_CYC > PRE_CYC) ? CAC_CYC : PRE_CYC);
  localparam int CNT_W = $clog2(MAXC + 1);

  seqState_t state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic lastRow, lastCol, lastPre, accept;

  assign lastRow = (cnt == CNT_W'(RCD_CYC - 1));
  assign lastCol = (cnt == CNT_W'(CAC_CYC - 1));
  assign lastPre = (cnt == CNT_W'(PRE_CYC - 1));

  assign reqReady = (state == S_IDLE) && !refreshGrant;
  assign accept   = reqReady && reqValid;

  always_comb begin
    stateNxt = state;
    cntNxt   = cnt + CNT_W'(1);
    unique case (state)
      S_IDLE: begin
        cntNxt = '0;
        if (accept) stateNxt = S_ROW;
      end
      S_ROW: if (lastRow) begin stateNxt = S_COL;  cntNxt = '0; end
      S_COL: if (lastCol) begin stateNxt = S_PRE;  cntNxt = '0; end
      S_PRE: if (lastPre) begin stateNxt = S_IDLE; cntNxt = '0; end
      default: begin stateNxt = S_IDLE; cntNxt = '0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
    end
  end

  always_comb begin
    strb.loadReq = accept;
    strb.rasOn   = (state == S_ROW) || (state == S_COL);
    strb.casOn   = (state == S_COL);
    strb.selCol  = ((state == S_ROW) && lastRow) || (state == S_COL) || (state == S_PRE);
    strb.weWin   = ((state == S_ROW) && lastRow) || (state == S_COL);
    strb.capRd   = (state == S_COL) && lastCol;
  end

  // R2: an accepted request always opens a fresh row phase
  p_accept_row_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (state == S_ROW && cnt == '0));

  // R9: a refresh grant in idle keeps the sequencer idle
  p_refresh_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && refreshGrant) |=> (state == S_IDLE));

  // R8: idle is only reached after a full precharge count
  p_pre_len_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && $past(state) == S_PRE) |-> ($past(cnt) == CNT_W'(PRE_CYC - 1)));

endmodule

// File: rtl/dseq_datapath.sv
module dseq_datapath
  import dseq_pkg::*;
#(
  parameter int ROW_W  = 10,
  parameter int COL_W  = 10,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              reqWrite,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDin,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRasN,
  output logic              memCasN,
  output logic              memWeN,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn
);

  logic [ROW_W-1:0]  rowQ;
  logic [COL_W-1:0]  colQ;
  logic [DATA_W-1:0] wdQ;
  logic              wrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowQ    <= '0;
      colQ    <= '0;
      wdQ     <= '0;
      wrQ     <= 1'b0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      if (strb.loadReq) begin
        rowQ <= reqRow;
        colQ <= reqCol;
        wdQ  <= reqWdata;
        wrQ  <= reqWrite;
      end
      rdValid <= strb.capRd && !wrQ;
      if (strb.capRd && !wrQ) rdData <= memDin;
    end
  end

  assign memAddr   = strb.selCol ? ADDR_W'(colQ) : ADDR_W'(rowQ);
  assign memRasN   = !strb.rasOn;
  assign memCasN   = !strb.casOn;
  assign memDoutEn = strb.weWin && wrQ;
  assign memWeN    = !memDoutEn;
  assign memDout   = wdQ;

  // R5: column strobe only inside a row strobe
  p_cas_in_ras_r5: assert property (@(posedge clk) disable iff (!rstN)
    !memCasN |-> !memRasN);

  // R4: column address held while column strobe is low
  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!memCasN && $past(!memCasN)) |-> $stable(memAddr));

  // R7: write enable already settled when the column strobe falls
  p_we_setup_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memCasN) |-> $stable(memWeN));

  // R6: read valid is a single-cycle pulse
  p_rd_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

endmodule

// File: rtl/dseq_top.sv
module dseq_top
  import dseq_pkg::*;
#(
  parameter int ROW_W  = 10,
  parameter int COL_W  = 10,
  parameter int DATA_W = 16,
  parameter int CLK_NS = 5,
  parameter int RAC_NS = 60,
  parameter int CAC_NS = 15,
  parameter int PRE_NS = 40
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic                                   reqValid,
  output logic                                   reqReady,
  input  logic                                   reqWrite,
  input  logic [ROW_W-1:0]                       reqRow,
  input  logic [COL_W-1:0]                       reqCol,
  input  logic [DATA_W-1:0]                      reqWdata,
  output logic [DATA_W-1:0]                      rdData,
  output logic                                   rdValid,
  input  logic                                   refreshGrant,
  output logic [(ROW_W>COL_W?ROW_W:COL_W)-1:0]   memAddr,
  output logic                                   memRasN,
  output logic                                   memCasN,
  output logic                                   memWeN,
  output logic [DATA_W-1:0]                      memDout,
  output logic                                   memDoutEn,
  input  logic [DATA_W-1:0]                      memDin
);

  localparam int ADDR_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int RAC_CYC = atLeast(cyclesOf(RAC_NS, CLK_NS), 3);
  localparam int CAC_CYC = atLeast(cyclesOf(CAC_NS, CLK_NS), 1);
  localparam int RCD_CYC = atLeast(RAC_CYC - CAC_CYC, 2);
  localparam int PRE_CYC = atLeast(cyclesOf(PRE_NS, CLK_NS), 1);

  strobe_t strb;

  dseq_ctrl #(
    .RCD_CYC(RCD_CYC),
    .CAC_CYC(CAC_CYC),
    .PRE_CYC(PRE_CYC)
  ) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .refreshGrant(refreshGrant),
    .reqReady    (reqReady),
    .strb        (strb)
  );

  dseq_datapath #(
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqWrite (reqWrite),
    .reqRow   (reqRow),
    .reqCol   (reqCol),
    .reqWdata (reqWdata),
    .memDin   (memDin),
    .rdData   (rdData),
    .rdValid  (rdValid),
    .memAddr  (memAddr),
    .memRasN  (memRasN),
    .memCasN  (memCasN),
    .memWeN   (memWeN),
    .memDout  (memDout),
    .memDoutEn(memDoutEn)
  );

endmodule

// File: tb/test_dseq_top.sv
module test_dseq_top;

  localparam int CLKP = 5;
  localparam int RACC = (60 + CLKP - 1) / CLKP;   // 12
  localparam int CACC = (15 + CLKP - 1) / CLKP;   // 3
  localparam int RCDC = RACC - CACC;              // 9
  localparam int PREC = (40 + CLKP - 1) / CLKP;   // 8

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [9:0]  reqRow = '0;
  logic [9:0]  reqCol = '0;
  logic [15:0] reqWdata = '0;
  logic [15:0] rdData;
  logic        rdValid;
  logic        refreshGrant = 1'b0;
  logic [9:0]  memAddr;
  logic        memRasN, memCasN, memWeN, memDoutEn;
  logic [15:0] memDout;
  logic [15:0] memDin = 16'hbeef;

  int compared = 0;
  int mismatched = 0;
  logic [15:0] mem [int];

  always #2.5 clk = ~clk;

  dseq_top i_dseq_top (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqRow(reqRow), .reqCol(reqCol), .reqWdata(reqWdata),
    .rdData(rdData), .rdValid(rdValid), .refreshGrant(refreshGrant),
    .memAddr(memAddr), .memRasN(memRasN), .memCasN(memCasN), .memWeN(memWeN),
    .memDout(memDout), .memDoutEn(memDoutEn), .memDin(memDin)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  function automatic int keyOf(input logic [9:0] r, input logic [9:0] c);
    return {12'd0, r, c};
  endfunction

  function automatic logic [15:0] memVal(input logic [9:0] r, input logic [9:0] c);
    int k = keyOf(r, c);
    if (mem.exists(k)) return mem[k];
    return k[15:0] ^ 16'h5a3c;
  endfunction

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // one access; grantCyc > 0 holds refresh and request together first
  task automatic doAccess(input bit wr, input logic [9:0] r, input logic [9:0] c,
                          input logic [15:0] wd, input int grantCyc);
    logic [15:0] expRd;
    @(negedge clk);
    reqWrite = wr; reqRow = r; reqCol = c; reqWdata = wd; reqValid = 1'b1;
    if (grantCyc > 0) begin
      refreshGrant = 1'b1;
      for (int g = 0; g < grantCyc; g++) begin
        #1;
        chk("R9 ready under refresh", reqReady, 1'b0);
        @(negedge clk);
        chk("R9 ras idle under refresh", memRasN, 1'b1);
      end
      refreshGrant = 1'b0;
    end
    #1;
    chk("R2 ready before accept", reqReady, 1'b1);
    expRd = memVal(r, c);
    @(negedge clk);
    reqValid = 1'b0;
    reqRow = 10'($urandom); reqCol = 10'($urandom); reqWdata = 16'($urandom);
    for (int n = 1; n <= RACC + PREC + 1; n++) begin
      chk("R3 R5 R8 ras", memRasN, (n <= RACC) ? 1'b0 : 1'b1);
      chk("R4 R5 cas", memCasN, (n > RCDC && n <= RACC) ? 1'b0 : 1'b1);
      if (n < RCDC) chk("R3 row address", memAddr, r);
      else if (n <= RACC) chk("R4 column address", memAddr, c);
      chk("R7 we", memWeN, (wr && n >= RCDC && n <= RACC) ? 1'b0 : 1'b1);
      chk("R7 dout enable", memDoutEn, (wr && n >= RCDC && n <= RACC) ? 1'b1 : 1'b0);
      chk("R2 ready low", reqReady, (n <= RACC + PREC) ? 1'b0 : 1'b1);
      chk("R6 rd valid", rdValid, (!wr && n == RACC + 1) ? 1'b1 : 1'b0);
      if (!wr && n == RACC + 1) chk("R6 rd data", rdData, expRd);
      if (n == RCDC + 1) begin
        if (wr) begin
          chk("R7 write data", memDout, wd);
          mem[keyOf(r, c)] = memDout;
        end else begin
          memDin = expRd;
        end
      end
      if (n == RACC + 1) memDin = 16'hbeef;
      if (n < RACC + PREC + 1) @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ras", memRasN, 1'b1);
    chk("R1 cas", memCasN, 1'b1);
    chk("R1 we", memWeN, 1'b1);
    chk("R1 doe", memDoutEn, 1'b0);
    chk("R1 rdvalid", rdValid, 1'b0);
    rstN = 1'b1;
    #1;
    chk("R1 ready", reqReady, 1'b1);

    // directed: read of unwritten cell, write then read back, refresh collision
    doAccess(1'b0, 10'h3ff, 10'h001, 16'h0, 0);
    doAccess(1'b1, 10'h155, 10'h2aa, 16'hc3a5, 0);
    doAccess(1'b0, 10'h155, 10'h2aa, 16'h0, 3);
    doAccess(1'b1, 10'h000, 10'h3ff, 16'hffff, 1);
    doAccess(1'b0, 10'h000, 10'h3ff, 16'h0, 0);

    // random mix over a small address space
    for (int i = 0; i < 60; i++) begin
      bit wr = 1'($urandom);
      logic [9:0] r = ($urandom % 4 == 0) ? 10'($urandom) : 10'($urandom % 4);
      logic [9:0] c = 10'($urandom % 4);
      int gc = ($urandom % 5 == 0) ? int'($urandom % 4) + 1 : 0;
      int idle = $urandom % 3;
      repeat (idle) @(negedge clk);
      doAccess(wr, r, c, 16'($urandom), gc);
    end
    finishRun();
  end

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finishRun();
  end

endmodule